// File: doc/BRIEF.md
# FIR multiply-accumulate engine

This block computes one output of a finite impulse response filter. It keeps two small internal stores. One is a circular history of input samples, which advances by one slot on every sample write. The other is a coefficient bank that is written by address. When a run is started, the engine takes one tap per clock. On each clock it multiplies a sample by a coefficient at full signed precision and adds the product into an accumulator that carries guard bits above the product width. In that same clock it reads the operands for the next tap. The sample index steps backwards from the newest entry and wraps around the end of the store. The coefficient index steps forwards from zero.

The accumulator is never limited while a run is in progress. Only when the final sum is moved into the result register is it clamped to the output width, which is twice the data width. A clamp sets a flag that stays set until reset. The operand fetch and the accumulate form a two-stage pipeline, so a run of T taps delivers its result strobe T+2 clocks after the start is accepted. Writes that arrive while a run is in progress would disturb the data being read, so they are discarded and reported.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `busy`, `done`, `ovf`, `wr_rej` and `result` are all zero.
- R2: A run of T taps gives the sum over k = 0..T-1 of coef[k] * x[newest-k]. The sample index wraps modulo TAPS, and every product keeps its full 2*DW bits. `done` is high for exactly one clock, sampled T+2 clock edges after the edge that accepted `start`, and `result` holds the value from that clock onward.
- R3: A partial sum may leave the 2*DW-bit range without any clamping. If the final sum is back in range, it is stored exactly and `ovf` stays low.
- R4: A final sum above 2^(2*DW-1)-1 is stored as that maximum. A final sum below -2^(2*DW-1) is stored as that minimum.
- R5: `ovf` goes high on the clock in which a clamped value is stored, and it stays high until reset.
- R6: Each accepted sample write fills the slot after the previous one, wrapping modulo TAPS. The most recently accepted sample is the newest entry x[newest].
- R7: A sample or coefficient write is ignored if it is sampled while `busy` is high or together with `start`. On the following clock, `wr_rej` is high for one cycle.
- R8: `start` while `busy` is high is ignored. Exactly one `done` is produced for each accepted start.
- R9: A `len` of 0 or greater than TAPS runs all TAPS taps. Any other `len` runs `len` taps.
- R10: `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a filter run (accepted when idle) |
| len | input | $clog2(TAPS+1) | Number of taps for the run |
| smp_we | input | 1 | Push one sample into the history |
| smp_wdata | input | DW | Sample value, two's complement |
| coef_we | input | 1 | Write one coefficient |
| coef_waddr | input | $clog2(TAPS) | Coefficient index |
| coef_wdata | input | DW | Coefficient value, two's complement |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock strobe: result updated |
| result | output | 2*DW | Clamped filter output, two's complement |
| ovf | output | 1 | Sticky clamp indicator |
| wr_rej | output | 1 | One-clock strobe: a write was discarded |

## Verification
The properties assume that `start` and the write strobes come from logic clocked by `clk` and are stable around the rising edge. They also assume that `len` stays constant in the clock where `start` is accepted. The stimulus changes every input on the falling edge only, and it holds `len` until `start` is withdrawn. Writes during a run, and a start during a run, are injected on purpose. Because `ovf` is sticky, the clamp checks are assumed to come after every run that expects `ovf` low, and the stimulus orders its runs that way.

// File: rtl/fir_mac_pkg.sv
// Package: shared types for the FIR multiply-accumulate engine.
// Assumes nothing beyond standard SystemVerilog.
package fir_mac_pkg;

    // Run sequencer states: idle, fetching operands, draining the pipeline.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_state_t;

endpackage

// File: rtl/fir_sample_ring.sv
// Module: circular sample history. Each accepted write goes to the slot
// the write pointer names, and the pointer then moves up by one, wrapping
// at DEPTH. Reads are registered while ren is high.
// Assumes: DEPTH >= 2; raddr < DEPTH; callers gate we themselves.
module fir_sample_ring #(
    parameter int DW    = 24,
    parameter int DEPTH = 16,
    parameter int AIW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic signed [DW-1:0]  wdata,
    input  logic                  ren,
    input  logic [AIW-1:0]        raddr,
    output logic signed [DW-1:0]  rdata,
    output logic [AIW-1:0]        wptr
);
    localparam logic [AIW-1:0] LAST = AIW'(DEPTH - 1);

    logic signed [DW-1:0] mem [DEPTH];

    // Store the incoming sample at the current write slot.
    always_ff @(posedge clk) begin
        if (we) mem[wptr] <= wdata;
    end

    // Move the write pointer forward modulo DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)    wptr <= '0;
        else if (we)   wptr <= (wptr == LAST) ? '0 : wptr + AIW'(1);
    end

    // Registered operand read for the multiply stage.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata <= '0;
        else if (ren)  rdata <= mem[raddr];
    end
endmodule

// File: rtl/fir_coef_bank.sv
// Module: addressed coefficient store with a registered read port.
// Assumes: DEPTH >= 2; writes to an index >= DEPTH are dropped.
module fir_coef_bank #(
    parameter int DW    = 24,
    parameter int DEPTH = 16,
    parameter int AIW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AIW-1:0]        waddr,
    input  logic signed [DW-1:0]  wdata,
    input  logic                  ren,
    input  logic [AIW-1:0]        raddr,
    output logic signed [DW-1:0]  rdata
);
    logic signed [DW-1:0] mem [DEPTH];
    logic                 addr_ok;

    // Reject indices beyond the populated depth.
    assign addr_ok = (32'(waddr) < DEPTH);

    // Write one coefficient at the given index.
    always_ff @(posedge clk) begin
        if (we && addr_ok) mem[waddr] <= wdata;
    end

    // Registered operand read for the multiply stage.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata <= '0;
        else if (ren)  rdata <= mem[raddr];
    end
endmodule

// File: rtl/fir_mac_seq.sv
// Module: run sequencer. It accepts start when idle and then issues one
// operand fetch per clock for the run length. The sample pointer starts at
// the newest entry and counts down, and the coefficient pointer starts at
// zero and counts up, both wrapping modulo TAPS. The sequencer stays busy
// until the accumulator reports the final store.
// Assumes: len is stable in the clock where start is accepted.
module fir_mac_seq
    import fir_mac_pkg::*;
#(
    parameter int TAPS = 16,
    parameter int LW   = $clog2(TAPS + 1),
    parameter int AIW  = $clog2(TAPS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LW-1:0]   len,
    input  logic [AIW-1:0]  wptr,
    input  logic            fin,
    output logic            busy,
    output logic            accept,
    output logic            rd_en,
    output logic            rd_last,
    output logic [AIW-1:0]  sptr,
    output logic [AIW-1:0]  cptr
);
    localparam logic [AIW-1:0] LAST  = AIW'(TAPS - 1);
    localparam logic [LW-1:0]  FULL  = LW'(TAPS);

    seq_state_t     state;
    logic [LW-1:0]  remain;
    logic [LW-1:0]  eff_len;
    logic [AIW-1:0] newest;

    // Out-of-range lengths select the full tap count.
    assign eff_len = (len == '0 || len > FULL) ? FULL : len;
    // The most recent sample sits one slot behind the write pointer.
    assign newest  = (wptr == '0) ? LAST : wptr - AIW'(1);

    assign busy    = (state != SQ_IDLE);
    assign accept  = start && (state == SQ_IDLE);
    assign rd_en   = (state == SQ_FETCH);
    assign rd_last = rd_en && (remain == '0);

    // Walk through the taps and wait for the final store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            remain <= '0;
            sptr   <= '0;
            cptr   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state  <= SQ_FETCH;
                        sptr   <= newest;
                        cptr   <= '0;
                        remain <= eff_len - LW'(1);
                    end
                end
                SQ_FETCH: begin
                    sptr <= (sptr == '0) ? LAST : sptr - AIW'(1);
                    cptr <= (cptr == LAST) ? '0 : cptr + AIW'(1);
                    if (remain == '0) state  <= SQ_DRAIN;
                    else              remain <= remain - LW'(1);
                end
                SQ_DRAIN: begin
                    if (fin) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fir_mac_acc.sv
// Module: multiply-accumulate stage with output clamping. The product is
// kept at full 2*DW bits and sign-extended into a GUARD-bit-wider
// accumulator, with no limiting between taps. After the last tap the sum
// is clamped to 2*DW bits when it is stored, and the sticky flag records
// any clamp.
// Assumes: clr is only raised while no operands are in flight.
module fir_mac_acc #(
    parameter int DW    = 24,
    parameter int GUARD = 8,
    parameter int PW    = 2 * DW,
    parameter int AW    = PW + GUARD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  op_v,
    input  logic                  op_last,
    input  logic signed [DW-1:0]  smp,
    input  logic signed [DW-1:0]  coef,
    output logic                  fin,
    output logic                  done,
    output logic [PW-1:0]         result,
    output logic                  ovf
);
    localparam logic [PW-1:0] MAXV = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] MINV = {1'b1, {(PW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc;
    logic [GUARD:0]       hi;
    logic                 in_range;
    logic [PW-1:0]        clamped;

    assign prod     = smp * coef;
    assign hi       = acc[AW-1:PW-1];
    assign in_range = (&hi) || !(|hi);
    assign clamped  = in_range ? acc[PW-1:0] : (acc[AW-1] ? MINV : MAXV);

    // Clear at run start, then add one full-width product per tap.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clr)   acc <= '0;
        else if (op_v)  acc <= acc + {{GUARD{prod[PW-1]}}, prod};
    end

    // Mark the clock after the last tap has been added.
    always_ff @(posedge clk) begin
        if (!rst_n) fin <= 1'b0;
        else        fin <= op_v && op_last;
    end

    // Store the clamped sum, pulse done and keep the sticky clamp flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                result <= clamped;
                ovf    <= ovf || !in_range;
            end
        end
    end
endmodule

// File: rtl/fir_mac_engine.sv
// Module: top of the FIR multiply-accumulate engine. It joins the sample
// history, the coefficient bank, the run sequencer and the accumulate
// stage into a two-stage fetch/accumulate pipeline. Writes that would
// disturb a run are discarded and reported.
// Assumes: TAPS >= 2; all inputs are synchronous to clk.
module fir_mac_engine #(
    parameter int DW    = 24,
    parameter int TAPS  = 16,
    parameter int GUARD = 8,
    localparam int LW   = $clog2(TAPS + 1),
    localparam int AIW  = $clog2(TAPS),
    localparam int PW   = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LW-1:0]   len,
    input  logic            smp_we,
    input  logic [DW-1:0]   smp_wdata,
    input  logic            coef_we,
    input  logic [AIW-1:0]  coef_waddr,
    input  logic [DW-1:0]   coef_wdata,
    output logic            busy,
    output logic            done,
    output logic [PW-1:0]   result,
    output logic            ovf,
    output logic            wr_rej
);
    logic                 accept, rd_en, rd_last, fin;
    logic                 op_v, op_last, blocked;
    logic [AIW-1:0]       wptr, sptr, cptr;
    logic signed [DW-1:0] smp_q, coef_q;

    // Writes collide with a run in progress or with a start on the same clock.
    assign blocked = busy || start;

    // Flag a discarded write on the following clock.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_rej <= 1'b0;
        else        wr_rej <= (smp_we || coef_we) && blocked;
    end

    // Carry the fetch valid and last markers alongside the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_v    <= 1'b0;
            op_last <= 1'b0;
        end else begin
            op_v    <= rd_en;
            op_last <= rd_last;
        end
    end

    fir_sample_ring #(.DW(DW), .DEPTH(TAPS), .AIW(AIW)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (smp_we && !blocked),
        .wdata (smp_wdata),
        .ren   (rd_en),
        .raddr (sptr),
        .rdata (smp_q),
        .wptr  (wptr)
    );

    fir_coef_bank #(.DW(DW), .DEPTH(TAPS), .AIW(AIW)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we && !blocked),
        .waddr (coef_waddr),
        .wdata (coef_wdata),
        .ren   (rd_en),
        .raddr (cptr),
        .rdata (coef_q)
    );

    fir_mac_seq #(.TAPS(TAPS), .LW(LW), .AIW(AIW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .len     (len),
        .wptr    (wptr),
        .fin     (fin),
        .busy    (busy),
        .accept  (accept),
        .rd_en   (rd_en),
        .rd_last (rd_last),
        .sptr    (sptr),
        .cptr    (cptr)
    );

    fir_mac_acc #(.DW(DW), .GUARD(GUARD)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .op_v    (op_v),
        .op_last (op_last),
        .smp     (smp_q),
        .coef    (coef_q),
        .fin     (fin),
        .done    (done),
        .result  (result),
        .ovf     (ovf)
    );
endmodule

// File: rtl/fir_mac_chk.sv
// Module: property checker for the FIR engine, bound to its top.
// Assumes: inputs are synchronous to clk; rst_n is active low.
module fir_mac_chk #(
    parameter int PW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          smp_we,
    input logic          coef_we,
    input logic          busy,
    input logic          done,
    input logic [PW-1:0] result,
    input logic          ovf,
    input logic          wr_rej
);
    localparam logic [PW-1:0] MAXV = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] MINV = {1'b1, {(PW-1){1'b0}}};

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R4
    clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (done && (result == MAXV || result == MINV)));

    // R7
    reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rej |-> $past(smp_we || coef_we));

    // R8
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);
endmodule

bind fir_mac_engine fir_mac_chk #(.PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .smp_we  (smp_we),
    .coef_we (coef_we),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .ovf     (ovf),
    .wr_rej  (wr_rej)
);

// File: tb/tb_fir_mac_engine.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops them on done.
module tb_fir_mac_engine;
    localparam int DW = 24, TAPS = 16, LW = 5, AIW = 4, PW = 48;
    localparam longint MAXV = (64'sd1 <<< 47) - 1;
    localparam longint MINV = -(64'sd1 <<< 47);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [LW-1:0] len = '0;
    logic smp_we = 1'b0, coef_we = 1'b0;
    logic [DW-1:0] smp_wdata = '0, coef_wdata = '0;
    logic [AIW-1:0] coef_waddr = '0;
    logic busy, done, ovf, wr_rej;
    logic [PW-1:0] result;

    fir_mac_engine #(.DW(DW), .TAPS(TAPS), .GUARD(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len),
        .smp_we(smp_we), .smp_wdata(smp_wdata), .coef_we(coef_we),
        .coef_waddr(coef_waddr), .coef_wdata(coef_wdata), .busy(busy),
        .done(done), .result(result), .ovf(ovf), .wr_rej(wr_rej)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0, n_done = 0;
    bit finished = 1'b0;
    longint s_m [TAPS];
    longint c_m [TAPS];
    int wp = 0;
    longint q_res [$];
    int     q_cyc [$];
    string  q_tag [$];

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_of(int l);
        return (l == 0 || l > TAPS) ? TAPS : l;
    endfunction

    function automatic longint model(int l);
        longint sum = 0;
        int newest = (wp + TAPS - 1) % TAPS;
        for (int k = 0; k < eff_of(l); k++)
            sum += c_m[k] * s_m[(newest - k + TAPS) % TAPS];
        if (sum > MAXV) return MAXV;
        if (sum < MINV) return MINV;
        return sum;
    endfunction

    task automatic put_smp(longint v);
        @(negedge clk);
        smp_we = 1'b1; smp_wdata = v[DW-1:0];
        @(negedge clk);
        smp_we = 1'b0;
        s_m[wp] = v; wp = (wp + 1) % TAPS;
    endtask

    task automatic put_coef(int a, longint v);
        @(negedge clk);
        coef_we = 1'b1; coef_waddr = a[AIW-1:0]; coef_wdata = v[DW-1:0];
        @(negedge clk);
        coef_we = 1'b0;
        c_m[a] = v;
    endtask

    // Push the expected result, then pulse start for one clock.
    task automatic launch(int l, string tag);
        @(negedge clk);
        q_res.push_back(model(l));
        q_cyc.push_back(cyc + eff_of(l) + 3);
        q_tag.push_back(tag);
        start = 1'b1; len = l[LW-1:0];
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q_res.size() != 0 || busy);
        @(negedge clk);
    endtask

    task automatic run(int l, string tag);
        launch(l, tag);
        wait_idle();
    endtask

    // Monitor: compare every done against the oldest expected entry.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (q_res.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R8 unexpected done actual=1 expected=0");
            end else begin
                string t = q_tag.pop_front();
                check({t, " result"}, longint'($signed(result)), q_res.pop_front());
                check({t, " latency"}, longint'(cyc), longint'(q_cyc.pop_front()));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", longint'(busy), 0);
        check("R1 done", longint'(done), 0);
        check("R1 ovf", longint'(ovf), 0);
        check("R1 wr_rej", longint'(wr_rej), 0);
        check("R1 result", longint'(result), 0);
        rst_n = 1'b1;

        for (int i = 0; i < TAPS; i++) put_coef(i, (i * i * 3 - 100) * 1000 + i);
        for (int i = 0; i < TAPS; i++) put_smp(i * 37911 - 300000);

        // R2: full and partial lengths, with busy checked while running (R10)
        launch(16, "R2 len16");
        check("R10 busy after start", longint'(busy), 1);
        wait_idle();
        check("R10 busy after done", longint'(busy), 0);
        run(5, "R2 len5");
        run(1, "R2 len1");
        // R9: out-of-range lengths
        run(0, "R9 len0");
        run(20, "R9 len20");
        // R6: pointer wrap
        put_smp(-4000000);
        put_smp(1234567);
        put_smp(-77);
        run(16, "R6 wrap len16");
        run(3, "R6 wrap len3");

        // R7: writes during a run are discarded
        launch(16, "R7 run");
        @(negedge clk); smp_we = 1'b1; smp_wdata = 24'h123456;
        @(negedge clk); smp_we = 1'b0;
        check("R7 wr_rej smp", longint'(wr_rej), 1);
        coef_we = 1'b1; coef_waddr = '0; coef_wdata = 24'h7FFFFF;
        @(negedge clk); coef_we = 1'b0;
        check("R7 wr_rej coef", longint'(wr_rej), 1);
        @(negedge clk);
        check("R7 wr_rej clears", longint'(wr_rej), 0);
        wait_idle();
        // R7: write together with start
        @(negedge clk);
        q_res.push_back(model(16)); q_cyc.push_back(cyc + 19); q_tag.push_back("R7 start+write");
        start = 1'b1; len = 5'd16; smp_we = 1'b1; smp_wdata = 24'h0ABCDE;
        @(negedge clk);
        start = 1'b0; smp_we = 1'b0;
        check("R7 wr_rej with start", longint'(wr_rej), 1);
        wait_idle();
        run(16, "R7 contents unchanged");

        // R8: start while busy is ignored
        d0 = n_done;
        launch(16, "R8 run");
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle();
        repeat (25) @(negedge clk);
        check("R8 done count", longint'(n_done - d0), 1);
        check("R8 idle", longint'(busy), 0);

        // R3: partial sums leave the range, final sum returns to zero
        for (int i = 0; i < TAPS; i++) put_smp(8388607);
        for (int i = 0; i < TAPS; i++) put_coef(i, i < 4 ? 8388607 : (i < 8 ? -8388607 : 0));
        run(8, "R3 guard growth");
        check("R3 ovf low", longint'(ovf), 0);

        // R4/R5: positive and negative clamp
        for (int i = 0; i < 8; i++) put_coef(i, 8388607);
        run(8, "R4 clamp max");
        check("R5 ovf set", longint'(ovf), 1);
        for (int i = 0; i < 8; i++) put_coef(i, -8388608);
        run(8, "R4 clamp min");
        for (int i = 0; i < TAPS; i++) put_coef(i, i - 5);
        run(16, "R5 normal run");
        check("R5 ovf sticky", longint'(ovf), 1);

        summary();
        $finish;
    end
endmodule